// File: doc/BRIEF.md
# Flash Program/Erase Sequencer

This block sits on the host side of a parallel NOR-style flash. It drives the flash through a simple synchronous bus master port with one-cycle write and read strobes, an address, write data, and returned read data qualified by a valid flag. A client hands it one request at a time. The request writes one word, or erases the whole array, one sector or one block. The sequencer sends the unlock-and-command write train the flash expects. It then waits for the internal operation to finish by watching the toggling status bit.

A status read can land at the exact moment the flash finishes. Such a read may look settled when it is not. For that reason, one matching pair of status reads is not enough. Completion needs two further reads that agree. After a word write, one last read compares the stored value with the intended word and raises an error flag on a mismatch. Each operation kind has its own polling time limit, given in microseconds and converted to clock cycles through a clock-frequency parameter. The end of every operation is signalled by a single-cycle pulse, either `op_done` or `op_timeout`.

Top module: `flash_op_sequencer`

## Requirements
- R1: A request with `req_op` = 0 (word write) issues exactly four bus writes on consecutive cycles, in this order:
  - data 00AAh to address 05555h
  - data 0055h to address 02AAAh
  - data 00A0h to address 05555h
  - `req_data` to `req_addr`
- R2: Erase requests issue exactly six bus writes on consecutive cycles:
  - data 00AAh to 05555h
  - data 0055h to 02AAAh
  - data 0080h to 05555h
  - data 00AAh to 05555h
  - data 0055h to 02AAAh
  - a final write that depends on `req_op`:
    - `req_op` = 1 (whole array): 0010h to 05555h
    - `req_op` = 2 (sector): 0030h to `req_addr`
    - `req_op` = 3 (block): 0050h to `req_addr`
- R3: After the last command write, the block polls with reads of `req_addr`. Completion is taken after four consecutive polling reads return the same value of data bit 6; any read whose bit 6 differs from the previous read restarts the count. `op_done` rises the cycle after the read that completes it (or after the verify read for a word write).
- R4: After polling completes for a word write, one further read of `req_addr` is made. `op_err` is set with `op_done` when that read differs from `req_data`, is cleared when a request is accepted, and is never set by an erase.
- R5: If polling has not completed, the block counts cycles from the first polling cycle. The limit is `PROG_TO_US`, `ERASE_TO_US` (sector and block) or `CHIP_TO_US` microseconds, each multiplied by `CLK_MHZ`. The block issues no further read once the limit is reached and pulses `op_timeout` instead of `op_done`.
- R6: `req_ready` is high only when idle; a request is accepted only while `req_ready` is high, and `req_valid` while busy causes no extra bus traffic.
- R7: `op_done` and `op_timeout` are single-cycle pulses, never high together, and `req_ready` is high the cycle after either.
- R8: After reset, `req_ready` is high and `bus_wr`, `bus_rd`, `op_done`, `op_timeout` and `op_err` are low.
- R9: `bus_wr` and `bus_rd` are never high in the same cycle, and no read is issued while an earlier read has not returned `bus_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while `req_ready` is high |
| req_op | input | 2 | 0 word write, 1 whole-array erase, 2 sector erase, 3 block erase |
| req_addr | input | AW | Target word, sector or block address |
| req_data | input | DW | Word to write |
| req_ready | output | 1 | Idle and able to take a request |
| bus_wr | output | 1 | One-cycle bus write strobe |
| bus_rd | output | 1 | One-cycle bus read strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Read data from the flash |
| bus_rvalid | input | 1 | Read data valid |
| op_done | output | 1 | One-cycle completion pulse |
| op_err | output | 1 | Verify mismatch of the last word write |
| op_timeout | output | 1 | One-cycle polling timeout pulse |

## Verification
The command train starts the cycle after acceptance and runs one write per cycle. The bench therefore compares the whole logged write train once the operation has ended, instead of sampling each write at a fixed cycle. The polling outcome is due one cycle after the deciding read returns. The bench sees that read arrive two cycles after the strobe, waits on falling edges for the pulse, and then compares the number of reads against a count worked out from its own status-bit pattern. The timeout pulse lands between limit+2 and limit+5 cycles after the last command write, because the limit is only checked when a read would be issued; the bench accepts exactly that window. The single-cycle nature of the pulse is checked on the next falling edge.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        OP_WORD   = 2'd0,
        OP_CHIP   = 2'd1,
        OP_SECTOR = 2'd2,
        OP_BLOCK  = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CMD,
        S_POLL_RD,
        S_POLL_WAIT,
        S_VFY_RD,
        S_VFY_WAIT,
        S_DONE,
        S_TMO
    } seq_state_e;

    localparam logic [15:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [15:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [7:0]  KEY_A         = 8'hAA;
    localparam logic [7:0]  KEY_B         = 8'h55;
    localparam logic [7:0]  CODE_WORD     = 8'hA0;
    localparam logic [7:0]  CODE_ERASE    = 8'h80;
    localparam logic [7:0]  CODE_CHIP     = 8'h10;
    localparam logic [7:0]  CODE_SECTOR   = 8'h30;
    localparam logic [7:0]  CODE_BLOCK    = 8'h50;

    localparam int WORD_STEPS  = 4;
    localparam int ERASE_STEPS = 6;
    localparam int STATUS_BIT  = 6;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int steps_of(input op_e op);
        return (op == OP_WORD) ? WORD_STEPS : ERASE_STEPS;
    endfunction

endpackage

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int AW = 18,
    parameter int DW = 16,
    parameter int SW = 3
) (
    input  op_e             op,
    input  logic [SW-1:0]   step,
    input  logic [AW-1:0]   tgt_addr,
    input  logic [DW-1:0]   tgt_data,
    output logic [AW-1:0]   cmd_addr,
    output logic [DW-1:0]   cmd_data,
    output logic            cmd_last
);
    localparam logic [AW-1:0] ADDR_A = AW'(UNLOCK_ADDR_A);
    localparam logic [AW-1:0] ADDR_B = AW'(UNLOCK_ADDR_B);

    logic [7:0] final_code;

    always_comb begin
        unique case (op)
            OP_CHIP:   final_code = CODE_CHIP;
            OP_SECTOR: final_code = CODE_SECTOR;
            default:   final_code = CODE_BLOCK;
        endcase
    end

    always_comb begin
        cmd_addr = ADDR_A;
        cmd_data = DW'(KEY_A);
        cmd_last = (int'(step) == steps_of(op) - 1);
        if (op == OP_WORD) begin
            unique case (step)
                SW'(0): begin cmd_addr = ADDR_A; cmd_data = DW'(KEY_A); end
                SW'(1): begin cmd_addr = ADDR_B; cmd_data = DW'(KEY_B); end
                SW'(2): begin cmd_addr = ADDR_A; cmd_data = DW'(CODE_WORD); end
                default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
            endcase
        end else begin
            unique case (step)
                SW'(0): begin cmd_addr = ADDR_A; cmd_data = DW'(KEY_A); end
                SW'(1): begin cmd_addr = ADDR_B; cmd_data = DW'(KEY_B); end
                SW'(2): begin cmd_addr = ADDR_A; cmd_data = DW'(CODE_ERASE); end
                SW'(3): begin cmd_addr = ADDR_A; cmd_data = DW'(KEY_A); end
                SW'(4): begin cmd_addr = ADDR_B; cmd_data = DW'(KEY_B); end
                default: begin
                    cmd_addr = (op == OP_CHIP) ? ADDR_A : tgt_addr;
                    cmd_data = DW'(final_code);
                end
            endcase
        end
    end

endmodule

// File: rtl/flash_toggle_poll.sv
module flash_toggle_poll #(
    parameter int CONFIRM_READS = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample_valid,
    input  logic status_bit,
    output logic settled
);
    localparam int NEED = CONFIRM_READS + 1;
    localparam int RW   = $clog2(NEED + 1);

    logic          have_prev;
    logic          prev_bit;
    logic [RW-1:0] run_len;
    logic          same;

    assign same    = have_prev && (status_bit == prev_bit);
    assign settled = sample_valid && same && (run_len == RW'(NEED - 1));

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_prev <= 1'b0;
            prev_bit  <= 1'b0;
            run_len   <= '0;
        end else if (sample_valid) begin
            have_prev <= 1'b1;
            prev_bit  <= status_bit;
            if (same && run_len != RW'(NEED))
                run_len <= run_len + 1'b1;
            else if (!same)
                run_len <= '0;
        end
    end

endmodule

// File: rtl/flash_op_timer.sv
module flash_op_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expired
);
    logic [TW-1:0] cnt;

    assign expired = (cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (run && !expired)
            cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/flash_op_sequencer.sv
module flash_op_sequencer
    import flash_seq_pkg::*;
#(
    parameter int AW            = 18,
    parameter int DW            = 16,
    parameter int CLK_MHZ       = 125,
    parameter int PROG_TO_US    = 40,
    parameter int ERASE_TO_US   = 50000,
    parameter int CHIP_TO_US    = 200000,
    parameter int CONFIRM_READS = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          bus_wr,
    output logic          bus_rd,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_rvalid,
    output logic          op_done,
    output logic          op_err,
    output logic          op_timeout
);
    localparam int PROG_LIM  = PROG_TO_US * CLK_MHZ;
    localparam int ERASE_LIM = ERASE_TO_US * CLK_MHZ;
    localparam int CHIP_LIM  = CHIP_TO_US * CLK_MHZ;
    localparam int MAX_LIM   = max3(PROG_LIM, ERASE_LIM, CHIP_LIM);
    localparam int TW        = $clog2(MAX_LIM + 1);
    localparam int SW        = $clog2(ERASE_STEPS);

    typedef struct packed {
        op_e           op;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } req_t;

    seq_state_e    state;
    req_t          req_q;
    logic [SW-1:0] step;
    logic          err_q;

    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic          cmd_last;
    logic          settled;
    logic          tmo_hit;
    logic [TW-1:0] limit;
    logic          poll_sample;
    logic          in_poll;

    flash_cmd_seq #(.AW(AW), .DW(DW), .SW(SW)) u_cmd (
        .op       (req_q.op),
        .step     (step),
        .tgt_addr (req_q.addr),
        .tgt_data (req_q.data),
        .cmd_addr (cmd_addr),
        .cmd_data (cmd_data),
        .cmd_last (cmd_last)
    );

    assign poll_sample = (state == S_POLL_WAIT) && bus_rvalid;
    assign in_poll     = (state == S_POLL_RD) || (state == S_POLL_WAIT);

    flash_toggle_poll #(.CONFIRM_READS(CONFIRM_READS)) u_poll (
        .clk          (clk),
        .rst          (rst),
        .clear        (state == S_CMD),
        .sample_valid (poll_sample),
        .status_bit   (bus_rdata[STATUS_BIT]),
        .settled      (settled)
    );

    always_comb begin
        unique case (req_q.op)
            OP_WORD: limit = TW'(PROG_LIM);
            OP_CHIP: limit = TW'(CHIP_LIM);
            default: limit = TW'(ERASE_LIM);
        endcase
    end

    flash_op_timer #(.TW(TW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .clear   (state == S_CMD),
        .run     (in_poll),
        .limit   (limit),
        .expired (tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= S_IDLE;
            req_q <= '0;
            step  <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    req_q <= '{op: op_e'(req_op), addr: req_addr, data: req_data};
                    step  <= '0;
                    err_q <= 1'b0;
                    state <= S_CMD;
                end
                S_CMD: begin
                    step <= step + 1'b1;
                    if (cmd_last) state <= S_POLL_RD;
                end
                S_POLL_RD:
                    state <= tmo_hit ? S_TMO : S_POLL_WAIT;
                S_POLL_WAIT: if (bus_rvalid) begin
                    if (settled)
                        state <= (req_q.op == OP_WORD) ? S_VFY_RD : S_DONE;
                    else
                        state <= S_POLL_RD;
                end
                S_VFY_RD:
                    state <= S_VFY_WAIT;
                S_VFY_WAIT: if (bus_rvalid) begin
                    err_q <= (bus_rdata != req_q.data);
                    state <= S_DONE;
                end
                S_DONE:  state <= S_IDLE;
                S_TMO:   state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = (state == S_IDLE);
    assign bus_wr     = (state == S_CMD);
    assign bus_rd     = ((state == S_POLL_RD) && !tmo_hit) || (state == S_VFY_RD);
    assign bus_addr   = (state == S_CMD) ? cmd_addr : req_q.addr;
    assign bus_wdata  = (state == S_CMD) ? cmd_data : '0;
    assign op_done    = (state == S_DONE);
    assign op_timeout = (state == S_TMO);
    assign op_err     = err_q;

endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
    parameter int AW = 18,
    parameter int DW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          req_ready,
    input logic          bus_wr,
    input logic          bus_rd,
    input logic          bus_rvalid,
    input logic          op_done,
    input logic          op_err,
    input logic          op_timeout
);
    logic rd_pending;

    always_ff @(posedge clk) begin
        if (rst)             rd_pending <= 1'b0;
        else if (bus_rd)     rd_pending <= 1'b1;
        else if (bus_rvalid) rd_pending <= 1'b0;
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        op_done |=> !op_done);
    assert_tmo_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        op_timeout |=> !op_timeout);
    assert_end_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(op_done && op_timeout));
    assert_back_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_timeout) |=> req_ready);
    assert_one_strobe_R9: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr && bus_rd));
    assert_one_read_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_pending && !bus_rvalid) |-> !bus_rd);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!bus_wr && !bus_rd));
    assert_done_after_read_R3: assert property (@(posedge clk) disable iff (rst)
        op_done |-> $past(bus_rvalid));
    assert_err_with_done_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(op_err) |-> op_done);

endmodule

bind flash_op_sequencer flash_seq_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_ready  (req_ready),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_rvalid (bus_rvalid),
    .op_done    (op_done),
    .op_err     (op_err),
    .op_timeout (op_timeout)
);

// File: tb/sim_flash_op_sequencer.sv
module sim_flash_op_sequencer;
    localparam int AW = 18, DW = 16;
    localparam int MHZ = 1, PT = 60, ET = 90, CT = 120;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic req_ready, bus_wr, bus_rd, op_done, op_err, op_timeout;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic bus_rvalid = 1'b0;

    always #4 clk = ~clk;

    flash_op_sequencer #(.AW(AW), .DW(DW), .CLK_MHZ(MHZ), .PROG_TO_US(PT),
        .ERASE_TO_US(ET), .CHIP_TO_US(CT)) u0 (.*);

    int tests = 0, fails = 0;

    // flash model
    logic [15:0] pat = '0;
    int pat_len = 0;
    bit tog_forever = 0;
    logic [DW-1:0] final_word = '0;
    logic [AW-1:0] exp_rd_addr = '0;
    bit clear_log = 0;
    int rd_cnt = 0, wr_cnt = 0, bad_rd = 0;
    logic [AW-1:0] wr_a [16];
    logic [DW-1:0] wr_d [16];
    logic v1 = 0;
    logic [DW-1:0] d1 = '0;

    function automatic logic [DW-1:0] resp(input int k);
        if (tog_forever) return (k % 2 == 1) ? 16'h0F4F : 16'h0F0F;
        if (k < pat_len) return 16'h0F0F | (DW'(pat[k]) << 6);
        return final_word;
    endfunction

    always @(posedge clk) begin
        if (clear_log) begin
            rd_cnt <= 0; wr_cnt <= 0; bad_rd <= 0; v1 <= 0; bus_rvalid <= 0;
        end else begin
            v1 <= bus_rd;
            bus_rvalid <= v1;
            bus_rdata <= d1;
            if (bus_rd) begin
                d1 <= resp(rd_cnt);
                rd_cnt <= rd_cnt + 1;
                if (bus_addr != exp_rd_addr) bad_rd <= bad_rd + 1;
            end
            if (bus_wr) begin
                if (wr_cnt < 16) begin
                    wr_a[wr_cnt] <= bus_addr;
                    wr_d[wr_cnt] <= bus_wdata;
                end
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_nwr(input int op);
        return (op == 0) ? 4 : 6;
    endfunction

    function automatic logic [AW-1:0] exp_a(input int op, input int i, input logic [AW-1:0] t);
        if (op == 0) return (i == 3) ? t : ((i == 1) ? 18'h02AAA : 18'h05555);
        if (i == 5) return (op == 1) ? 18'h05555 : t;
        return (i == 1 || i == 4) ? 18'h02AAA : 18'h05555;
    endfunction

    function automatic logic [DW-1:0] exp_d(input int op, input int i, input logic [DW-1:0] d);
        if (op == 0) begin
            case (i) 0: return 16'h00AA; 1: return 16'h0055; 2: return 16'h00A0; default: return d; endcase
        end
        case (i)
            0, 3: return 16'h00AA;
            1, 4: return 16'h0055;
            2: return 16'h0080;
            default: return (op == 1) ? 16'h0010 : ((op == 2) ? 16'h0030 : 16'h0050);
        endcase
    endfunction

    function automatic int exp_polls();
        for (int k = 3; k < 400; k++)
            if (resp(k)[6] == resp(k-1)[6] && resp(k-1)[6] == resp(k-2)[6]
                && resp(k-2)[6] == resp(k-3)[6])
                return k + 1;
        return -1;
    endfunction

    task automatic run_op(input int op, input logic [AW-1:0] addr, input logic [DW-1:0] data,
                          input logic [15:0] p, input int plen, input logic [DW-1:0] fin,
                          input bit forever_t, input bit intrude);
        int cyc, last_wr, npoll, nrd, lim, bad_seq;
        bit got_done, got_tmo, e_err;
        @(negedge clk);
        pat = p; pat_len = plen; final_word = fin; tog_forever = forever_t;
        exp_rd_addr = addr; clear_log = 1;
        @(negedge clk);
        clear_log = 0;
        req_valid = 1; req_op = 2'(op); req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 0;
        chk(op_err == 0, "R4", "err cleared on accept", op_err, 0);
        cyc = 0; last_wr = 0; got_done = 0; got_tmo = 0;
        while (cyc < 5000) begin
            @(negedge clk);
            cyc++;
            if (intrude && cyc == 3) begin
                chk(req_ready == 0, "R6", "ready low while busy", req_ready, 0);
                req_valid = 1; req_op = 2'((op + 1) % 4); req_addr = addr ^ 18'h1;
            end
            if (intrude && cyc == 4) req_valid = 0;
            if (bus_wr) last_wr = cyc;
            if (op_done || op_timeout) begin
                got_done = op_done; got_tmo = op_timeout;
                break;
            end
        end
        bad_seq = 0;
        for (int i = 0; i < exp_nwr(op) && i < 16; i++)
            if (wr_a[i] !== exp_a(op, i, addr) || wr_d[i] !== exp_d(op, i, data)) bad_seq++;
        chk(wr_cnt == exp_nwr(op), (op == 0) ? "R1" : "R2", "write count", wr_cnt, exp_nwr(op));
        chk(bad_seq == 0, (op == 0) ? "R1" : "R2", "write train mismatches", bad_seq, 0);
        chk(bad_rd == 0, "R3", "reads off target", bad_rd, 0);
        if (forever_t) begin
            lim = MHZ * ((op == 0) ? PT : ((op == 1) ? CT : ET));
            chk(got_tmo && !got_done, "R5", "timeout pulse", got_tmo, 1);
            chk(cyc - last_wr >= lim + 2 && cyc - last_wr <= lim + 5, "R5",
                "timeout distance", cyc - last_wr, lim + 2);
        end else begin
            npoll = exp_polls();
            nrd = npoll + ((op == 0) ? 1 : 0);
            e_err = (op == 0) && (resp(npoll) != data);
            chk(got_done && !got_tmo, "R3", "done pulse", got_done, 1);
            chk(rd_cnt == nrd, "R3", "read count", rd_cnt, nrd);
            chk(op_err == e_err, "R4", "err flag", op_err, e_err);
        end
        @(negedge clk);
        chk(!op_done && !op_timeout, "R7", "pulse one cycle", op_done | op_timeout, 0);
        chk(req_ready == 1, "R7", "ready after end", req_ready, 1);
        if (intrude)
            chk(wr_cnt == exp_nwr(op), "R6", "no traffic from busy request", wr_cnt, exp_nwr(op));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected end");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [15:0] pats [5];
        int lens [5];
        logic [DW-1:0] d;
        pats[0] = 16'h0000; lens[0] = 0;
        pats[1] = 16'h002A; lens[1] = 6;
        pats[2] = 16'h0076; lens[2] = 8;
        pats[3] = 16'h0007; lens[3] = 4;
        pats[4] = 16'h002E; lens[4] = 6;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R8 reset state
        chk(req_ready == 1, "R8", "ready", req_ready, 1);
        chk(!bus_wr && !bus_rd, "R8", "strobes", bus_wr | bus_rd, 0);
        chk(!op_done && !op_timeout && !op_err, "R8", "flags", op_done | op_timeout | op_err, 0);
        for (int op = 0; op < 4; op++)
            for (int p = 0; p < 5; p++) begin
                d = 16'h5A00 | DW'(op << 4) | DW'(p);
                run_op(op, 18'h30000 + AW'(op * 16'h1111) + AW'(p * 3), d,
                       pats[p], lens[p], d, 0, (p == 2));
            end
        // R4 verify mismatch, then a clean write clears it
        run_op(0, 18'h00123, 16'hBEEF, pats[1], lens[1], 16'hBEEF ^ 16'h0100, 0, 0);
        run_op(0, 18'h3FFFF, 16'hFFFF, pats[2], lens[2], 16'h0000, 0, 0);
        run_op(0, 18'h00124, 16'h1234, pats[0], lens[0], 16'h1234, 0, 0);
        // R5 timeouts for every kind
        for (int op = 0; op < 4; op++)
            run_op(op, 18'h20000 + AW'(op), 16'h0042, 16'h0, 0, 16'h0042, 1, (op == 1));
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule